// File: doc/BRIEF.md
# Ethernet Fast-Path Frame Classifier

This block watches the receive word stream of an Ethernet port and decides, for every frame, whether it may take the fast path or must be handed to software on the slow path. Software programs five match values: the destination MAC, the source MAC, the ethertype, a flags word and an expected sequence number. Each frame header is compared word by word against those values as it streams past.

The frame itself leaves the block one cycle later, unchanged, with its start and end markers. On the end-of-frame word the block also raises a fast-path indication when every header field matched. Each fast-path frame advances the expected sequence number by one. Every other frame is slow path and sets a sticky status flag, which software clears by writing 1 to it.

The header is six 32-bit words:

| Word | Contents |
|------|----------|
| 0 | destination bytes 0..3 |
| 1 | destination bytes 4..5 (upper half) and source bytes 0..1 (lower half) |
| 2 | source bytes 2..5 |
| 3 | ethertype in bits 31:16; bits 15:0 are not compared |
| 4 | flags |
| 5 | sequence number |

Top module: `fastpath_classifier`

## Requirements
- R1: After reset, `out_valid`, `out_fast` and `slow_flag` are 0, and `seq_expected` is 0.
- R2: A word accepted with `in_valid` and either `in_sof` or an open frame appears on `out_data`, `out_sof` and `out_eof` with `out_valid` one cycle later. A valid word outside a frame that lacks `in_sof` is dropped and produces no output.
- R3: Header word 0 must equal the value at config address 1, word 1 the value at address 2, and word 2 the value at address 3. These hold the destination and source MAC bytes.
- R4: Bits 31:16 of header word 3 must equal bits 31:16 of config address 4. Bits 15:0 of word 3 are never compared.
- R5: Header word 4 must equal the flags value at config address 0, and header word 5 must equal `seq_expected`.
- R6: `out_fast` is 1 only together with `out_eof` and `out_valid`, and only when all header comparisons of R3 to R5 held.
- R7: A frame that ends before header word 5 has arrived is slow path, even if every word it did carry matched. This includes a single-word frame.
- R8: Each fast-path frame increments `seq_expected` by one, modulo 2^32. The new value is visible in the same cycle as `out_fast`.
- R9: A config write to address 5 loads `seq_expected` from `cfg_wdata`. In the same cycle as a fast-path increment, the write wins.
- R10: Any frame that ends without being fast path sets `slow_flag`, which stays set. A config write to address 6 with bit 0 set clears it; bit 0 clear has no effect. A set and a clear in the same cycle leave the flag set.
- R11: A new `in_sof` always starts a new header comparison, including when it comes right after the previous frame's end word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| cfg_we | input | 1 | config write strobe |
| cfg_addr | input | 3 | config address: 0 flags, 1..3 MAC words, 4 ethertype, 5 sequence, 6 status clear |
| cfg_wdata | input | 32 | config write data |
| in_valid | input | 1 | input word valid |
| in_sof | input | 1 | first word of frame |
| in_eof | input | 1 | last word of frame |
| in_data | input | 32 | input word |
| out_valid | output | 1 | output word valid |
| out_sof | output | 1 | first word of frame |
| out_eof | output | 1 | last word of frame |
| out_data | output | 32 | output word |
| out_fast | output | 1 | frame classified fast path (on end word) |
| seq_expected | output | 32 | expected sequence number |
| slow_flag | output | 1 | sticky slow-path status |

## Verification
The bench targets the following corner cases, each with the failure it would expose:

- **Frames shorter than the header.** A design that classifies on the comparisons seen so far would call a five-word frame, or a single-word frame, fast path.
- **Sequence wrap from all ones.** A design that saturates, or widens the counter, would not read back zero after the wrap.
- **Concurrent writes on the end word.** The bench issues a sequence write on the end word of a fast frame, and a flag clear on the end word of a slow frame. A design with the wrong priority keeps the incremented sequence number or loses the flag.
- **Don't-care and stream edges.** The lower ethertype half changes between frames. Stray words without a start marker are sent. Frames arrive back to back and with idle gaps. A design that compares the whole of word 3 would misclassify; one that keeps comparison state across a start marker, or forwards stray words, would corrupt the next result.

// File: rtl/fastpath_classifier.sv
module fastpath_classifier #(
  parameter int DW = 32,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_addr,
  input  logic [DW-1:0] cfg_wdata,
  input  logic          in_valid,
  input  logic          in_sof,
  input  logic          in_eof,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  output logic          out_sof,
  output logic          out_eof,
  output logic [DW-1:0] out_data,
  output logic          out_fast,
  output logic [DW-1:0] seq_expected,
  output logic          slow_flag
);
  localparam int HDR_WORDS = 6;
  localparam int IW = $clog2(HDR_WORDS + 1);
  localparam int HW = DW / 2;
  localparam logic [IW-1:0] LAST_HDR = IW'(HDR_WORDS - 1);
  localparam logic [IW-1:0] PAST_HDR = IW'(HDR_WORDS);

  logic [DW-1:0] m_flags, m_w0, m_w1, m_w2, m_etype;
  logic          in_frame, ok_acc;
  logic [IW-1:0] idx;
  logic          word_ok;

  wire accept = in_valid & (in_sof | in_frame);
  wire [IW-1:0] cur_idx = in_sof ? '0 : idx;
  wire ok_so_far = in_sof | ok_acc;
  wire fast_now = accept & in_eof & ok_so_far & word_ok & (cur_idx >= LAST_HDR);
  wire slow_now = accept & in_eof & ~fast_now;
  wire wr_seq = cfg_we & (cfg_addr == AW'(5));
  wire wr_clr = cfg_we & (cfg_addr == AW'(6)) & cfg_wdata[0];

  always_comb begin
    case (cur_idx)
      IW'(0): word_ok = (in_data == m_w0);
      IW'(1): word_ok = (in_data == m_w1);
      IW'(2): word_ok = (in_data == m_w2);
      IW'(3): word_ok = (in_data[DW-1:HW] == m_etype[DW-1:HW]);
      IW'(4): word_ok = (in_data == m_flags);
      IW'(5): word_ok = (in_data == seq_expected);
      default: word_ok = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_flags <= '0;
      m_w0    <= '0;
      m_w1    <= '0;
      m_w2    <= '0;
      m_etype <= '0;
    end else if (cfg_we) begin
      case (cfg_addr)
        AW'(0): m_flags <= cfg_wdata;
        AW'(1): m_w0    <= cfg_wdata;
        AW'(2): m_w1    <= cfg_wdata;
        AW'(3): m_w2    <= cfg_wdata;
        AW'(4): m_etype <= cfg_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_frame <= 1'b0;
      idx      <= '0;
      ok_acc   <= 1'b0;
    end else if (accept) begin
      in_frame <= ~in_eof;
      idx      <= (cur_idx == PAST_HDR) ? PAST_HDR : cur_idx + IW'(1);
      ok_acc   <= ok_so_far & word_ok;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seq_expected <= '0;
      slow_flag    <= 1'b0;
    end else begin
      if (wr_seq)        seq_expected <= cfg_wdata;
      else if (fast_now) seq_expected <= seq_expected + DW'(1);
      if (slow_now)      slow_flag <= 1'b1;
      else if (wr_clr)   slow_flag <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sof   <= 1'b0;
      out_eof   <= 1'b0;
      out_fast  <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= accept;
      out_sof   <= accept & in_sof;
      out_eof   <= accept & in_eof;
      out_fast  <= fast_now;
      if (accept) out_data <= in_data;
    end
  end
endmodule

// File: rtl/fastpath_classifier_checker.sv
module fastpath_classifier_checker #(
  parameter int DW = 32,
  parameter int AW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_we,
  input logic [AW-1:0] cfg_addr,
  input logic [DW-1:0] cfg_wdata,
  input logic          in_valid,
  input logic          out_valid,
  input logic          out_eof,
  input logic          out_fast,
  input logic [DW-1:0] seq_expected,
  input logic          slow_flag
);
  p_out_follows_in_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid));

  p_fast_on_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_fast |-> (out_valid && out_eof));

  p_seq_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_fast && !$past(cfg_we && cfg_addr == AW'(5)))
      |-> seq_expected == $past(seq_expected) + DW'(1));

  p_seq_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(seq_expected) |-> ($past(cfg_we && cfg_addr == AW'(5)) || out_fast));

  p_seq_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_we && cfg_addr == AW'(5)) |-> seq_expected == $past(cfg_wdata));

  p_slow_sets_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_eof && !out_fast) |-> slow_flag);

  p_slow_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(slow_flag) |-> $past(cfg_we && cfg_addr == AW'(6) && cfg_wdata[0]));
endmodule

bind fastpath_classifier fastpath_classifier_checker #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
  .cfg_wdata(cfg_wdata), .in_valid(in_valid), .out_valid(out_valid),
  .out_eof(out_eof), .out_fast(out_fast), .seq_expected(seq_expected),
  .slow_flag(slow_flag)
);

// File: tb/fastpath_classifier_bench.sv
module fastpath_classifier_bench;
  logic clk = 0, rst_n = 0;
  logic cfg_we = 0;
  logic [2:0] cfg_addr = 0;
  logic [31:0] cfg_wdata = 0;
  logic in_valid = 0, in_sof = 0, in_eof = 0;
  logic [31:0] in_data = 0;
  logic out_valid, out_sof, out_eof, out_fast, slow_flag;
  logic [31:0] out_data, seq_expected;

  fastpath_classifier u_fastpath_classifier (.*);

  always #4 clk = ~clk;

  int errors = 0, checks = 0;
  string req = "R1";

  // reference model state
  logic [31:0] m_cfg [0:4];
  logic [31:0] m_q [$];
  bit m_in = 0, m_flag = 0;
  logic [31:0] m_seq = 0;
  bit e_valid = 0, e_sof = 0, e_eof = 0, e_fast = 0;
  logic [31:0] e_data = 0;

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", r, act, exp, $time);
    end
  endtask

  task automatic model();
    bit acc, fast;
    logic [31:0] nseq;
    acc = in_valid && (in_sof || m_in);
    e_valid = acc; e_sof = acc && in_sof; e_eof = acc && in_eof; e_fast = 0;
    if (acc) e_data = in_data;
    nseq = m_seq;
    if (acc) begin
      if (in_sof) m_q.delete();
      m_q.push_back(in_data);
      m_in = !in_eof;
      if (in_eof) begin
        fast = m_q.size() >= 6 && m_q[0] == m_cfg[1] && m_q[1] == m_cfg[2] &&
               m_q[2] == m_cfg[3] && m_q[3][31:16] == m_cfg[4][31:16] &&
               m_q[4] == m_cfg[0] && m_q[5] == m_seq;
        e_fast = fast;
        if (fast) nseq = m_seq + 1;
        else m_flag = 1;
        if (!fast) begin end
        else if (cfg_we && cfg_addr == 6 && cfg_wdata[0]) m_flag = 0;
        if (fast) ;
      end
    end
    if (!(acc && in_eof && !e_fast) && cfg_we && cfg_addr == 6 && cfg_wdata[0]
        && !(acc && in_eof && e_fast)) m_flag = 0;
    if (cfg_we && cfg_addr == 5) nseq = cfg_wdata;
    if (cfg_we && cfg_addr < 5) m_cfg[cfg_addr] = cfg_wdata;
    m_seq = nseq;
  endtask

  task automatic step();
    @(posedge clk);
    if (rst_n) model();
    #1;
    chk({req, " out_valid (R2)"}, 32'(out_valid), 32'(e_valid));
    if (e_valid) begin
      chk("R2 out_data", out_data, e_data);
      chk("R2 out_sof", 32'(out_sof), 32'(e_sof));
      chk("R2 out_eof", 32'(out_eof), 32'(e_eof));
    end
    chk({req, " out_fast (R6)"}, 32'(out_fast), 32'(e_fast));
    chk({req, " seq_expected (R8)"}, seq_expected, m_seq);
    chk({req, " slow_flag (R10)"}, 32'(slow_flag), 32'(m_flag));
    @(negedge clk);
    cfg_we = 0; in_valid = 0; in_sof = 0; in_eof = 0;
  endtask

  task automatic cfg(input logic [2:0] a, input logic [31:0] d);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    step();
  endtask

  logic [31:0] fr [$];

  task automatic hdr(input logic [31:0] seq, input logic [15:0] lo);
    fr.delete();
    fr.push_back(32'h0010_A4B2);
    fr.push_back(32'hC3D4_0050);
    fr.push_back(32'h56E7_F809);
    fr.push_back({16'h88B5, lo});
    fr.push_back(32'h0000_0A01);
    fr.push_back(seq);
  endtask

  task automatic send(input int gap, input bit ewe, input logic [2:0] ea,
                      input logic [31:0] ed);
    foreach (fr[i]) begin
      in_valid = 1; in_sof = (i == 0); in_eof = (i == fr.size() - 1);
      in_data = fr[i];
      if (i == fr.size() - 1 && ewe) begin
        cfg_we = 1; cfg_addr = ea; cfg_wdata = ed;
      end
      step();
      for (int g = 0; g < gap; g++) step();
    end
  endtask

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 5; i++) m_cfg[i] = 0;
    @(negedge clk); @(negedge clk);
    req = "R1"; step();
    rst_n = 1;
    req = "R1"; step();
    cfg(0, 32'h0000_0A01); cfg(1, 32'h0010_A4B2); cfg(2, 32'hC3D4_0050);
    cfg(3, 32'h56E7_F809); cfg(4, 32'h88B5_1234);
    // R2: stray words without start marker are dropped
    req = "R2";
    in_valid = 1; in_data = 32'hDEAD_BEEF; step();
    in_valid = 1; in_eof = 1; in_data = 32'h1; step();
    // R6 R8: full match, longer frame
    req = "R6"; hdr(0, 16'h0); fr.push_back(32'h11); fr.push_back(32'h22);
    send(0, 0, 0, 0);
    // R4: lower ethertype half differs, still fast; gaps inside frame
    req = "R4"; hdr(1, 16'hFFFF); send(1, 0, 0, 0);
    // R5: wrong sequence number
    req = "R5"; hdr(7, 16'h0); send(0, 0, 0, 0);
    // R10: clear with bit0=0 has no effect, then with 1 clears
    req = "R10"; cfg(6, 32'hFFFF_FFFE); cfg(6, 32'h1);
    // R3: destination mismatch, then source mismatch
    req = "R3"; hdr(2, 0); fr[0][8] = ~fr[0][8]; send(0, 0, 0, 0);
    req = "R3"; hdr(2, 0); fr[1][0] = ~fr[1][0]; send(0, 0, 0, 0);
    req = "R3"; hdr(2, 0); fr[2][31] = ~fr[2][31]; send(0, 0, 0, 0);
    // R4: upper ethertype mismatch
    req = "R4"; hdr(2, 0); fr[3][16] = ~fr[3][16]; send(0, 0, 0, 0);
    // R5: flags mismatch
    req = "R5"; hdr(2, 0); fr[4] = 32'h0000_0A00; send(0, 0, 0, 0);
    cfg(6, 32'h1);
    // R7: short frames
    req = "R7"; hdr(2, 0); void'(fr.pop_back()); send(0, 0, 0, 0);
    req = "R7"; fr.delete(); fr.push_back(32'h0010_A4B2); send(0, 0, 0, 0);
    // R10: set and clear in same cycle -> stays set
    req = "R10"; hdr(9, 0); send(0, 1, 6, 32'h1);
    cfg(6, 32'h1);
    // R6: exactly six words, back to back with R11 restart
    req = "R11"; hdr(2, 0); send(0, 0, 0, 0);
    hdr(3, 0); send(0, 0, 0, 0);
    // R11: new start mid-frame after mismatch restarts comparison
    req = "R11"; hdr(4, 0); fr[0] = 0; fr = fr[0:2]; fr.push_back(32'h0);
    foreach (fr[i]) begin in_valid = 1; in_sof = (i == 0); in_data = fr[i]; step(); end
    hdr(4, 0); send(0, 0, 0, 0);
    // R8: wrap from all ones
    req = "R8"; cfg(5, 32'hFFFF_FFFF); hdr(32'hFFFF_FFFF, 0); send(0, 0, 0, 0);
    hdr(0, 0); send(0, 0, 0, 0);
    // R9: write on end word of a fast frame wins
    req = "R9"; hdr(1, 0); send(0, 1, 5, 32'h0000_5000);
    hdr(32'h5000, 0); send(0, 0, 0, 0);
    req = "R1"; step(); step();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule